// File: doc/BRIEF.md
# Clocked Serial Byte Port with Strobe and Busy Handshake

This block moves one byte at a time over a synchronous serial link. It drives the shift clock itself and exchanges a byte with a receiving device in the same frame: it drives one bit out while it takes one bit in. The shift clock either comes from a divider on the block clock, where the select field picks the ratio, or follows an external clock input. The frame always has eight clock pulses and the most significant bit goes first. At the end of the frame the port raises a strobe pulse toward the receiver. It can then poll a busy line on a fixed grid of serial periods, and it starts no further frame until the receiver reports ready.

The host side is a plain parallel port. A write pulse loads a transmit byte and sets a data-written flag. The received byte can be read after each frame, and a completion flag marks it. A write made while bits are being shifted does not take effect and raises an error flag. When no byte is waiting at the point where the port becomes ready, it idles with the clock high. The next write then starts a frame after a fixed lead time.

Top module: `sio_strobe_port`

## Requirements
- R1: After reset the clock output and the data output are high, the strobe is low, the received byte is 0, and the data-written, completion and error flags are clear.
- R2: For select values 0 to 5 the clock phase (half period) lasts 4 << sel block-clock cycles, so the full period is 8 << sel cycles. Select values 6 and 7 choose the external clock, where every transition of the external clock input is one phase and is acted on at the first block-clock edge that sees the new level.
- R3: A frame has exactly eight low/high clock pulses. The first falling edge drives bit 7 of the transmit byte, and every later falling edge drives the next lower bit. The serial input is sampled on each rising edge.
- R4: At the eighth rising edge the eight sampled bits, first sample as bit 7, become the readable byte and the completion flag sets. An accepted host write clears the completion flag.
- R5: The strobe rises one phase after the eighth rising edge and stays high for two phases, a full period.
- R6: With busy polling enabled, the busy input is sampled 4, 6, 8, ... phases after the eighth rising edge. A low sample releases the port. A high sample waits for the next sample point.
- R7: If a byte has been written when the port is released, the first falling edge of the next frame comes three phases after the release point and the data-written flag is then cleared.
- R8: If no byte is waiting at release, the port idles with the clock high and starts no frame. A write in that state gives the first falling edge three phases after the clock edge that takes the write.
- R9: With busy polling disabled, the release point is the falling edge of the strobe, three phases after the eighth rising edge.
- R10: A host write made while the frame is shifting changes neither the transmit byte nor the data-written flag and sets the error flag. An accepted write clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Host write strobe, one cycle |
| wdata_i | input | 8 | Host transmit byte |
| rdata_o | output | 8 | Last received byte |
| pending_o | output | 1 | Transmit byte written and not yet sent |
| done_o | output | 1 | Frame completed since the last accepted write |
| err_o | output | 1 | Write arrived during shifting |
| clk_sel_i | input | 3 | Clock divider select; 6 and 7 select the external clock |
| busy_en_i | input | 1 | Enable busy polling after each frame |
| ext_sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Serial shift clock, idles high |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| strb_o | output | 1 | End-of-frame strobe |
| busy_i | input | 1 | Busy indication from the receiver |

## Verification
The embedded assertions check, on every cycle, that the clock and data outputs change only on a phase tick or a falling-edge or load event. They also check that the strobe never overlaps a low clock phase, that a frame starts only with a written byte, that a busy sample seen high keeps the port in its wait state, and that a write during shifting leaves the transmit byte alone and raises the error flag. Only the bench scenarios can show the absolute timing: the three-phase lead after a write or a release, the strobe offset and width, and where on the busy grid the port releases. They also cover the bit order of both directions, the timing in external clock mode, and the lack of activity when no byte is waiting. A behavioural receiver in the bench answers with its own bytes and holds busy for chosen windows.

// File: rtl/sio_strobe_pkg.sv
package sio_strobe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_POST
    } frame_state_e;

    // Phase counts measured in half periods of the shift clock.
    localparam int LEAD_TICKS      = 3;
    localparam int STRB_ON_TICK    = 1;
    localparam int STRB_OFF_TICK   = 3;
    localparam int BUSY_FIRST_TICK = 4;
    localparam int BUSY_STEP_TICKS = 2;

    typedef struct packed {
        logic load;
        logic fall;
        logic rise;
        logic last;
    } shift_ctl_t;

    function automatic int half_clocks(input int base, input int sel);
        return base << sel;
    endfunction

    function automatic logic is_external(input int sel, input int num_int);
        return sel >= num_int;
    endfunction

endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
    import sio_strobe_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int BASE_HALF = 4,
    parameter int NUM_INT   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ext_sck_i,
    output logic             tick_o
);
    localparam int MAX_HALF = BASE_HALF << (NUM_INT - 1);
    localparam int CW       = $clog2(MAX_HALF) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;
    logic          ext_mode;
    logic          ext_q;
    logic          int_tick;
    logic          ext_tick;

    assign ext_mode = is_external(int'(sel_i), NUM_INT);
    assign half_m1  = CW'(half_clocks(BASE_HALF, int'(sel_i)) - 1);
    assign int_tick = !ext_mode && !hold_i && (cnt == half_m1);
    assign ext_tick = ext_mode && (ext_sck_i != ext_q);
    assign tick_o   = int_tick || ext_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ext_q <= 1'b1;
        end else begin
            ext_q <= ext_sck_i;
            if (hold_i || ext_mode || int_tick) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/sio_shift_unit.sv
module sio_shift_unit
    import sio_strobe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  shift_ctl_t    ctl_i,
    input  logic [DW-1:0] tx_i,
    input  logic          si_i,
    output logic          so_o,
    output logic [DW-1:0] rx_o
);
    logic [DW-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            so_o  <= 1'b1;
            rx_o  <= '0;
        end else begin
            if (ctl_i.load) begin
                shreg <= tx_i;
                so_o  <= tx_i[DW-1];
            end else if (ctl_i.fall) begin
                so_o  <= shreg[DW-1];
            end else if (ctl_i.rise) begin
                shreg <= {shreg[DW-2:0], si_i};
            end
            if (ctl_i.last) begin
                rx_o <= {shreg[DW-2:0], si_i};
            end
        end
    end

    // R3: data output moves only at a load or a falling-edge event
    assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(so_o) |-> $past(ctl_i.load || ctl_i.fall));

endmodule

// File: rtl/sio_host_regs.sv
module sio_host_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          in_shift_i,
    input  logic          load_i,
    input  logic          last_i,
    output logic [DW-1:0] tx_buf_o,
    output logic          accept_o,
    output logic          pending_o,
    output logic          done_o,
    output logic          err_o
);
    assign accept_o = wr_i && !in_shift_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf_o  <= '0;
            pending_o <= 1'b0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            if (accept_o) begin
                tx_buf_o  <= wdata_i;
                pending_o <= 1'b1;
                done_o    <= 1'b0;
                err_o     <= 1'b0;
            end else begin
                if (load_i) begin
                    pending_o <= 1'b0;
                end
                if (wr_i) begin
                    err_o <= 1'b1;
                end
                if (last_i) begin
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R10: a write during shifting leaves the buffer and raises the error flag
    assert_reject_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_i && in_shift_i) |=> (err_o && $stable(tx_buf_o)));

    // R4: completion flag only rises from the final rising edge
    assert_done_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(last_i));

endmodule

// File: rtl/sio_frame_ctrl.sv
module sio_frame_ctrl
    import sio_strobe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       accept_i,
    input  logic       pending_i,
    input  logic       busy_en_i,
    input  logic       busy_i,
    output logic       sck_o,
    output logic       strb_o,
    output logic       in_shift_o,
    output logic       idle_o,
    output shift_ctl_t ctl_o
);
    localparam int EDGES = 2 * DW;
    localparam int SW    = $clog2(EDGES) + 1;

    frame_state_e  state;
    logic [SW-1:0] cnt;
    logic [SW-1:0] cnt_nx;
    logic          lead_done;
    logic          shift_done;
    logic          release_now;
    logic          busy_wait;

    assign cnt_nx     = cnt + SW'(1);
    assign lead_done  = (state == ST_LEAD) && tick_i && (cnt == SW'(LEAD_TICKS - 1));
    assign shift_done = (state == ST_SHIFT) && tick_i && (cnt == SW'(EDGES - 2));
    assign in_shift_o = (state == ST_SHIFT);
    assign idle_o     = (state == ST_IDLE);

    always_comb begin
        ctl_o.load = lead_done;
        ctl_o.fall = (state == ST_SHIFT) && tick_i && cnt[0];
        ctl_o.rise = (state == ST_SHIFT) && tick_i && !cnt[0];
        ctl_o.last = shift_done;
    end

    always_comb begin
        release_now = 1'b0;
        busy_wait   = 1'b0;
        if ((state == ST_POST) && tick_i) begin
            if (!busy_en_i) begin
                release_now = (cnt_nx >= SW'(STRB_OFF_TICK));
            end else if (cnt_nx >= SW'(BUSY_FIRST_TICK)) begin
                release_now = !busy_i;
                busy_wait   = busy_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sck_o  <= 1'b1;
            strb_o <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept_i) begin
                        state <= ST_LEAD;
                        cnt   <= '0;
                    end
                end
                ST_LEAD: begin
                    if (lead_done) begin
                        state <= ST_SHIFT;
                        cnt   <= '0;
                        sck_o <= 1'b0;
                    end else if (tick_i) begin
                        cnt <= cnt_nx;
                    end
                end
                ST_SHIFT: begin
                    if (tick_i) begin
                        sck_o <= ~sck_o;
                        if (shift_done) begin
                            state <= ST_POST;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                end
                ST_POST: begin
                    if (tick_i) begin
                        if (cnt_nx == SW'(STRB_ON_TICK)) begin
                            strb_o <= 1'b1;
                        end
                        if (cnt_nx == SW'(STRB_OFF_TICK)) begin
                            strb_o <= 1'b0;
                        end
                        if (release_now) begin
                            state <= (pending_i || accept_i) ? ST_LEAD : ST_IDLE;
                            cnt   <= '0;
                        end else if (busy_wait) begin
                            cnt <= SW'(BUSY_FIRST_TICK - BUSY_STEP_TICKS);
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the shift clock only moves on a phase tick
    assert_sck_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sck_o) |-> $past(tick_i));

    // R5: strobe is only high while the clock rests high
    assert_strobe_clock_high_R5: assert property (@(posedge clk) disable iff (rst)
        strb_o |-> sck_o);

    // R7: a frame begins only when a byte has been written
    assert_start_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
        lead_done |-> pending_i);

    // R6: a high busy sample keeps the port waiting
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
        busy_wait |=> (state == ST_POST));

endmodule

// File: rtl/sio_strobe_port.sv
module sio_strobe_port
    import sio_strobe_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SEL_W     = 3,
    parameter int BASE_HALF = 4,
    parameter int NUM_INT   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             pending_o,
    output logic             done_o,
    output logic             err_o,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic             busy_en_i,
    input  logic             ext_sck_i,
    output logic             sck_o,
    output logic             so_o,
    input  logic             si_i,
    output logic             strb_o,
    input  logic             busy_i
);
    logic          tick;
    logic          idle;
    logic          in_shift;
    logic          accept;
    logic [DW-1:0] tx_buf;
    shift_ctl_t    ctl;

    sio_tick_gen #(
        .SEL_W    (SEL_W),
        .BASE_HALF(BASE_HALF),
        .NUM_INT  (NUM_INT)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (idle),
        .sel_i    (clk_sel_i),
        .ext_sck_i(ext_sck_i),
        .tick_o   (tick)
    );

    sio_host_regs #(
        .DW(DW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .in_shift_i(in_shift),
        .load_i    (ctl.load),
        .last_i    (ctl.last),
        .tx_buf_o  (tx_buf),
        .accept_o  (accept),
        .pending_o (pending_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    sio_frame_ctrl #(
        .DW(DW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .accept_i  (accept),
        .pending_i (pending_o),
        .busy_en_i (busy_en_i),
        .busy_i    (busy_i),
        .sck_o     (sck_o),
        .strb_o    (strb_o),
        .in_shift_o(in_shift),
        .idle_o    (idle),
        .ctl_o     (ctl)
    );

    sio_shift_unit #(
        .DW(DW)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .ctl_i(ctl),
        .tx_i (tx_buf),
        .si_i (si_i),
        .so_o (so_o),
        .rx_o (rdata_o)
    );

endmodule

// File: tb/sio_strobe_port_tb.sv
module sio_strobe_port_tb;
    localparam int EXT_E    = 3;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       pending_o, done_o, err_o;
    logic [2:0] clk_sel_i = 3'd0;
    logic       busy_en_i = 1'b0;
    logic       ext_sck_i = 1'b1;
    logic       sck_o, so_o, strb_o;
    logic       si_i = 1'b1;
    logic       busy_i = 1'b0;

    always #2.5 clk = ~clk;

    sio_strobe_port u_dut (
        .clk(clk), .rst(rst), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .pending_o(pending_o), .done_o(done_o), .err_o(err_o), .clk_sel_i(clk_sel_i),
        .busy_en_i(busy_en_i), .ext_sck_i(ext_sck_i), .sck_o(sck_o), .so_o(so_o),
        .si_i(si_i), .strb_o(strb_o), .busy_i(busy_i)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int c_wr = 0;

    // peer model and monitor state
    int         fall_t [0:255];
    int         rise_t [0:255];
    int         sr_t   [0:31];
    int         sf_t   [0:31];
    logic [7:0] so_frame [0:31];
    logic [7:0] peer_tx  [0:31];
    int   nf = 0, nr = 0, nsr = 0, nsf = 0;
    logic [7:0] so_cap = 8'h00;
    logic p_sck = 1'b1, p_strb = 1'b0;
    int   peer_hold = 0;
    int   drop_at = -1;
    bit   ext_run = 1'b0;
    int   ext_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sck_o !== p_sck) begin
                if (sck_o == 1'b0) begin
                    fall_t[nf] = cyc;
                    si_i = peer_tx[nf / 8][7 - (nf % 8)];
                    nf++;
                end else begin
                    rise_t[nr] = cyc;
                    so_cap = {so_cap[6:0], so_o};
                    if (nr % 8 == 7) so_frame[nr / 8] = so_cap;
                    nr++;
                end
            end
            if (strb_o !== p_strb) begin
                if (strb_o) begin
                    sr_t[nsr] = cyc;
                    nsr++;
                    if (peer_hold > 0) begin
                        busy_i  = 1'b1;
                        drop_at = cyc + peer_hold;
                    end
                end else begin
                    sf_t[nsf] = cyc;
                    nsf++;
                end
            end
            if (busy_i && cyc == drop_at) busy_i = 1'b0;
            if (ext_run) begin
                ext_cnt++;
                if (ext_cnt == EXT_E) begin
                    ext_sck_i = ~ext_sck_i;
                    ext_cnt   = 0;
                end
            end
        end
        p_sck  = sck_o;
        p_strb = strb_o;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        wr_i    = 1'b1;
        wdata_i = d;
        c_wr    = cyc;
        tick();
        wr_i    = 1'b0;
    endtask

    task automatic check_rx(input int f, input logic [7:0] sl);
        while (nr < (f + 1) * 8) tick();
        check(rdata_o == sl, "R4 received byte", rdata_o, sl);
        check(done_o == 1'b1, "R4 completion flag", done_o, 1);
    endtask

    task automatic verify_frame(input int f, input int h, input logic [7:0] tx,
                                input logic [7:0] sl, input bit with_rx);
        int bad;
        int t0;
        if (with_rx) check_rx(f, sl);
        while (nr < (f + 1) * 8) tick();
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (rise_t[f*8+k] - fall_t[f*8+k] != h) bad++;
            if (k < 7 && fall_t[f*8+k+1] - rise_t[f*8+k] != h) bad++;
        end
        check(bad == 0, "R2 phase length", bad, 0);
        check(so_frame[f] == tx, "R3 serial out MSB first", so_frame[f], tx);
        t0 = rise_t[f*8+7];
        while (nsf < f + 1) tick();
        check(sr_t[f] == t0 + h, "R5 strobe delay", sr_t[f] - t0, h);
        check(sf_t[f] - sr_t[f] == 2 * h, "R5 strobe width", sf_t[f] - sr_t[f], 2 * h);
    endtask

    task automatic run_reset();
        rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        check(sck_o == 1'b1, "R1 clock idle high", sck_o, 1);
        check(so_o == 1'b1, "R1 data out high", so_o, 1);
        check(strb_o == 1'b0, "R1 strobe low", strb_o, 0);
        check(rdata_o == 8'h00, "R1 received byte", rdata_o, 0);
        check({pending_o, done_o, err_o} == 3'b000, "R1 flags clear",
              {pending_o, done_o, err_o}, 0);
    endtask

    task automatic run_single(input int sel, input logic [7:0] tx, input logic [7:0] sl);
        int f = nf / 8;
        int h = 4 << sel;
        clk_sel_i  = 3'(sel);
        busy_en_i  = 1'b0;
        peer_tx[f] = sl;
        host_write(tx);
        check(pending_o == 1'b1, "R7 data-written flag", pending_o, 1);
        while (nf <= f * 8) tick();
        check(fall_t[f*8] == c_wr + 1 + 3 * h, "R8 lead after write",
              fall_t[f*8] - c_wr - 1, 3 * h);
        check(pending_o == 1'b0, "R7 flag cleared at start", pending_o, 0);
        verify_frame(f, h, tx, sl, 1'b1);
        repeat (12 * h) tick();
        check(nf == (f + 1) * 8, "R8 no frame without data", nf, (f + 1) * 8);
        check(sck_o == 1'b1, "R8 idle clock high", sck_o, 1);
    endtask

    task automatic run_chain(input int sel, input bit en, input int hold,
                             input logic [7:0] tx1, input logic [7:0] sl1,
                             input logic [7:0] tx2, input logic [7:0] sl2,
                             input string tag);
        int f = nf / 8;
        int h = 4 << sel;
        int t0, s, d, expv;
        clk_sel_i  = 3'(sel);
        busy_en_i  = en;
        peer_hold  = hold;
        peer_tx[f] = sl1;
        peer_tx[f+1] = sl2;
        host_write(tx1);
        check_rx(f, sl1);
        while (nsr < f + 1) tick();
        host_write(tx2);
        peer_hold = 0;
        check(pending_o == 1'b1, "R7 data-written flag in wait", pending_o, 1);
        verify_frame(f, h, tx1, sl1, 1'b0);
        t0 = rise_t[f*8+7];
        if (!en) begin
            expv = t0 + 6 * h;
        end else begin
            s = t0 + 4 * h;
            d = (hold > 0) ? sr_t[f] + hold : -1;
            while (s <= d) s += 2 * h;
            expv = s + 3 * h;
        end
        while (nf <= (f + 1) * 8) tick();
        check(fall_t[(f+1)*8] == expv, tag, fall_t[(f+1)*8] - t0, expv - t0);
        verify_frame(f + 1, h, tx2, sl2, 1'b1);
    endtask

    task automatic run_overrun(input int sel);
        int f = nf / 8;
        int h = 4 << sel;
        clk_sel_i  = 3'(sel);
        busy_en_i  = 1'b0;
        peer_tx[f] = 8'h5A;
        host_write(8'hC3);
        while (nf < f * 8 + 3) tick();
        host_write(8'h00);
        check(err_o == 1'b1, "R10 error flag set", err_o, 1);
        check(pending_o == 1'b0, "R10 write not taken", pending_o, 0);
        verify_frame(f, h, 8'hC3, 8'h5A, 1'b1);
        repeat (10 * h) tick();
        check(nf == (f + 1) * 8, "R10 no frame from ignored write", nf, (f + 1) * 8);
        peer_tx[f+1] = 8'h81;
        host_write(8'h7E);
        check(err_o == 1'b0, "R10 error cleared by write", err_o, 0);
        check(done_o == 1'b0, "R4 completion cleared by write", done_o, 0);
        verify_frame(f + 1, h, 8'h7E, 8'h81, 1'b1);
    endtask

    task automatic run_external();
        int f = nf / 8;
        clk_sel_i  = 3'd7;
        busy_en_i  = 1'b0;
        peer_tx[f] = 8'h96;
        ext_run    = 1'b1;
        host_write(8'h2D);
        verify_frame(f, EXT_E, 8'h2D, 8'h96, 1'b1);
        ext_run = 1'b0;
    endtask

    initial begin
        wait (cyc >= WD_LIMIT);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual %0d expected %0d", cyc, WD_LIMIT);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_reset();
        run_single(0, 8'hA5, 8'h3C);
        run_chain(2, 1'b0, 0, 8'h1E, 8'hE1, 8'hF0, 8'h0F, "R9 release at strobe fall");
        run_chain(1, 1'b1, 0, 8'h55, 8'hAA, 8'h33, 8'hCC, "R6 first busy sample then R7 lead");
        run_chain(1, 1'b1, 5 * 8 + 1, 8'h69, 8'h96, 8'h80, 8'h01, "R6 busy grid then R7 lead");
        run_overrun(0);
        run_single(5, 8'h01, 8'h80);
        run_external();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule